// File: doc/BRIEF.md
# Edge-Interrupt GPIO Controller

A general-purpose I/O peripheral for up to 32 pins, each mapped to one bit position of every 32-bit register word. Software uses a small register port with a valid/ready request and a one-cycle read response. Through it, software sets each pin's direction and its polarity inversion, and writes the output latch. The latch can be written whole, or changed one bit at a time through atomic write-one set, clear and toggle strobes. Software also reads back the pin levels.

Each pin input passes through a two-flop synchroniser. After that, edge detection works on the logical level, which is the level after polarity inversion. Separate rising and falling enables let a pin report rising edges, falling edges or both. A detected edge sets a pending bit, which software clears by writing a 1 to it. An edge register keeps the direction of each pin's last captured edge. All pending bits are ORed onto one level interrupt line.

Top module: `gpio_edge_ctrl`

## Requirements
- R1: Registers sit at word offsets, with address bits [5:2] selecting them: 0x00 pending status (write 1 to clear), 0x04 edge direction (read-only), 0x08 rising enable, 0x0C falling enable, 0x10 data, 0x14 direction, 0x18 polarity, 0x1C set strobe, 0x20 clear strobe, 0x24 toggle strobe. Reads of the three strobe registers return 0.
- R2: The direction register drives `pin_oe` bit by bit. A 1 makes the pin an output and a 0 makes it an input.
- R3: Writing the data register loads the output latch. `pin_out` equals the latch XOR the polarity register.
- R4: A 1 bit written to the set, clear or toggle register sets, clears or inverts that latch bit. A 0 bit leaves the latch bit unchanged.
- R5: A data read returns the output latch for output pins. For input pins it returns the synchronised input XOR polarity, and a change on `pin_in` becomes visible two clock edges later.
- R6: A logical rising edge on a pin whose rising enable is 1 sets that pin's pending bit on the third clock edge after the input changes. With the enable at 0 the edge sets nothing.
- R7: A logical falling edge on a pin whose falling enable is 1 sets the pending bit. When both enables are 1, both kinds of edge are reported.
- R8: Edges are taken after polarity inversion. With polarity 1, a raw low-to-high change counts as a falling edge. A change of the polarity register by itself never creates an edge.
- R9: The edge register bit is 1 after the pin's last captured edge was rising, and 0 after it was falling.
- R10: Writing a 1 to a pending status bit clears it, and writing a 0 leaves it unchanged.
- R11: If an edge event and a clearing write hit the same pending bit in the same cycle, the bit stays set.
- R12: `irq` is high exactly while at least one pending bit is set.
- R13: Reset clears every register to 0. `req_ready` is always high. `rsp_valid` pulses for one cycle after each accepted read, with `rsp_rdata` holding the word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Register request valid |
| req_ready | output | 1 | Request accepted (always high) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Byte address of the register |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after the read |
| rsp_rdata | output | 32 | Read data |
| pin_in | input | NPINS | Asynchronous pin levels |
| pin_out | output | NPINS | Output levels after polarity inversion |
| pin_oe | output | NPINS | Output enable per pin |
| irq | output | 1 | Combined level interrupt |

## Verification
The edge logic is driven with raw rising and falling changes under four conditions: only the rising enable set, only the falling enable set, both set, and neither set. These runs show that each enable gates only its own edge kind. Repeating a raw rise with polarity 1 shows whether detection works on the logical level. Toggling the polarity with the input held steady shows that a polarity change creates no edge. A clearing write timed to land on the same edge as a new event tells event-wins from clear-wins. The strobe tests use bit patterns that mix 1s and 0s, which shows that 0 bits leave the latch alone.

// File: rtl/gpio_edge_ctrl.sv
module gpio_edge_ctrl #(
  parameter int NPINS = 32,
  parameter int AW    = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_write,
  input  logic [AW-1:0]    req_addr,
  input  logic [31:0]      req_wdata,
  output logic             rsp_valid,
  output logic [31:0]      rsp_rdata,
  input  logic [NPINS-1:0] pin_in,
  output logic [NPINS-1:0] pin_out,
  output logic [NPINS-1:0] pin_oe,
  output logic             irq
);

  localparam int IW = AW - 2;
  localparam logic [IW-1:0] A_STAT = IW'(0);
  localparam logic [IW-1:0] A_EDGE = IW'(1);
  localparam logic [IW-1:0] A_REN  = IW'(2);
  localparam logic [IW-1:0] A_FEN  = IW'(3);
  localparam logic [IW-1:0] A_DATA = IW'(4);
  localparam logic [IW-1:0] A_DIR  = IW'(5);
  localparam logic [IW-1:0] A_POL  = IW'(6);
  localparam logic [IW-1:0] A_SET  = IW'(7);
  localparam logic [IW-1:0] A_CLR  = IW'(8);
  localparam logic [IW-1:0] A_TOG  = IW'(9);

  logic [IW-1:0]    idx;
  logic             wr, rd;
  logic [NPINS-1:0] wmask;
  logic [NPINS-1:0] stat_q, edge_q, ren_q, fen_q, out_q, dir_q, pol_q;
  logic [NPINS-1:0] sync1_q, sync2_q, hist_q;
  logic [NPINS-1:0] raw_up, raw_dn, up, dn, ev, clr_mask, level;
  logic [NPINS-1:0] rd_sel;

  assign idx       = req_addr[AW-1:2];
  assign wr        = req_valid & req_write;
  assign rd        = req_valid & ~req_write;
  assign wmask     = req_wdata[NPINS-1:0];
  assign req_ready = 1'b1;

  assign raw_up = sync2_q & ~hist_q;
  assign raw_dn = ~sync2_q & hist_q;
  assign up     = (raw_up & ~pol_q) | (raw_dn & pol_q);
  assign dn     = (raw_dn & ~pol_q) | (raw_up & pol_q);
  assign ev     = (up & ren_q) | (dn & fen_q);

  assign clr_mask = (wr && idx == A_STAT) ? wmask : '0;
  assign level    = (dir_q & out_q) | (~dir_q & (sync2_q ^ pol_q));

  assign pin_out = out_q ^ pol_q;
  assign pin_oe  = dir_q;
  assign irq     = |stat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= '0;
      sync2_q <= '0;
      hist_q  <= '0;
    end else begin
      sync1_q <= pin_in;
      sync2_q <= sync1_q;
      hist_q  <= sync2_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      edge_q <= '0;
    end else begin
      stat_q <= (stat_q & ~clr_mask) | ev;
      edge_q <= (edge_q & ~ev) | (up & ev);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ren_q <= '0;
      fen_q <= '0;
      dir_q <= '0;
      pol_q <= '0;
      out_q <= '0;
    end else if (wr) begin
      case (idx)
        A_REN:   ren_q <= wmask;
        A_FEN:   fen_q <= wmask;
        A_DIR:   dir_q <= wmask;
        A_POL:   pol_q <= wmask;
        A_DATA:  out_q <= wmask;
        A_SET:   out_q <= out_q | wmask;
        A_CLR:   out_q <= out_q & ~wmask;
        A_TOG:   out_q <= out_q ^ wmask;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (idx)
      A_STAT:  rd_sel = stat_q;
      A_EDGE:  rd_sel = edge_q;
      A_REN:   rd_sel = ren_q;
      A_FEN:   rd_sel = fen_q;
      A_DATA:  rd_sel = level;
      A_DIR:   rd_sel = dir_q;
      A_POL:   rd_sel = pol_q;
      default: rd_sel = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd;
      if (rd) rsp_rdata <= 32'(rd_sel);
    end
  end

endmodule

// File: rtl/gpio_edge_ctrl_chk.sv
module gpio_edge_ctrl_chk #(
  parameter int NPINS = 32,
  parameter int AW    = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_write,
  input logic [AW-1:2]    idx,
  input logic [NPINS-1:0] wmask,
  input logic             rsp_valid,
  input logic [31:0]      rsp_rdata,
  input logic [NPINS-1:0] out_q,
  input logic [NPINS-1:0] stat_q,
  input logic [NPINS-1:0] ev
);
  localparam int IW = AW - 2;
  logic wr_set, wr_clr, wr_tog, rd_strobe;
  assign wr_set    = req_valid && req_write && idx == IW'(7);
  assign wr_clr    = req_valid && req_write && idx == IW'(8);
  assign wr_tog    = req_valid && req_write && idx == IW'(9);
  assign rd_strobe = req_valid && !req_write && (idx == IW'(7) || idx == IW'(8) || idx == IW'(9));

  // R4
  set_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_set |=> ((out_q & $past(wmask)) == $past(wmask)));
  // R4
  clr_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_clr |=> ((out_q & $past(wmask)) == '0));
  // R4
  tog_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_tog |=> (out_q == ($past(out_q) ^ $past(wmask))));
  // R1
  strobe_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_strobe |=> (rsp_rdata == 32'd0));
  // R13
  rsp_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid && !req_write));
  // R11
  event_sets_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev != '0) |=> ((stat_q & $past(ev)) == $past(ev)));
  // R10
  no_spurious_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat_q & ~$past(stat_q) & ~$past(ev)) == '0));
endmodule

bind gpio_edge_ctrl gpio_edge_ctrl_chk #(.NPINS(NPINS), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .idx(idx), .wmask(wmask), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
  .out_q(out_q), .stat_q(stat_q), .ev(ev)
);

// File: tb/gpio_edge_ctrl_bench.sv
module gpio_edge_ctrl_bench;
  localparam logic [5:0] STAT = 6'h00, EDGE = 6'h04, REN = 6'h08, FEN = 6'h0C,
                         DATA = 6'h10, DIR = 6'h14, POL = 6'h18, SETR = 6'h1C,
                         CLRR = 6'h20, TOGR = 6'h24;

  logic        clk = 0, rst_n = 0;
  logic        req_valid = 0, req_write = 0;
  logic [5:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        req_ready, rsp_valid, irq;
  logic [31:0] rsp_rdata, pin_in = '0, pin_out, pin_oe;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  gpio_edge_ctrl u_gpio_edge_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 0; req_write = 0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = a;
    @(negedge clk);
    req_valid = 0;
    if (!rsp_valid) begin
      checks++; errors++;
      $display("FAIL R13: actual rsp_valid 0 expected 1");
    end
    d = rsp_rdata;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R13 ready", {31'd0, req_ready}, 32'd1);
    chk("R2 oe reset", pin_oe, 32'd0);
    chk("R12 irq reset", {31'd0, irq}, 32'd0);
    rd(STAT, v); chk("R13 status reset", v, 32'd0);
    rd(DIR, v);  chk("R13 dir reset", v, 32'd0);
  endtask

  task automatic t_output();
    logic [31:0] v;
    wr(DIR, 32'h0000_FFFF);
    chk("R2 oe", pin_oe, 32'h0000_FFFF);
    wr(DATA, 32'h0000_00A5);
    chk("R3 out", pin_out, 32'h0000_00A5);
    wr(SETR, 32'h0000_0F00);
    chk("R4 set", pin_out, 32'h0000_0FA5);
    wr(CLRR, 32'h0000_0081);
    chk("R4 clear", pin_out, 32'h0000_0F24);
    wr(TOGR, 32'h0000_1004);
    chk("R4 toggle", pin_out, 32'h0000_1F20);
    rd(SETR, v); chk("R1 set reads zero", v, 32'd0);
    rd(TOGR, v); chk("R1 toggle reads zero", v, 32'd0);
    wr(POL, 32'h0000_0003);
    chk("R3 out inverted", pin_out, 32'h0000_1F23);
    rd(DATA, v); chk("R5 data outputs", v, 32'h0000_1F20);
    wr(POL, 32'd0);
  endtask

  task automatic t_input();
    logic [31:0] v;
    pin_in = 32'h00FF_0000;
    @(negedge clk); @(negedge clk);
    rd(DATA, v); chk("R5 data mixed", v, 32'h00FF_1F20);
    wr(POL, 32'h0F00_0000);
    rd(DATA, v); chk("R5 data input polarity", v, 32'h0FFF_1F20);
    wr(POL, 32'd0);
    pin_in = '0; settle();
  endtask

  task automatic t_rise_fall();
    logic [31:0] v;
    wr(REN, 32'h0001_0000);
    wr(FEN, 32'h0002_0000);
    pin_in = 32'h0003_0000;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R12 irq", {31'd0, irq}, 32'd1);
    rd(STAT, v); chk("R6 rising only on enabled pin", v, 32'h0001_0000);
    rd(EDGE, v); chk("R9 edge rising", v, 32'h0001_0000);
    wr(STAT, 32'h0000_0000);
    rd(STAT, v); chk("R10 write zero keeps", v, 32'h0001_0000);
    wr(STAT, 32'h0001_0000);
    rd(STAT, v); chk("R10 w1c", v, 32'd0);
    chk("R12 irq low", {31'd0, irq}, 32'd0);
    pin_in = '0; settle();
    rd(STAT, v); chk("R7 falling only on enabled pin", v, 32'h0002_0000);
    rd(EDGE, v); chk("R9 edge falling", v, 32'h0001_0000);
    wr(STAT, 32'hFFFF_FFFF);
    wr(REN, 32'h0004_0000); wr(FEN, 32'h0004_0000);
    pin_in = 32'h0004_0000; settle();
    rd(STAT, v); chk("R7 both rise", v, 32'h0004_0000);
    rd(EDGE, v); chk("R9 both rising", v, 32'h0005_0000);
    wr(STAT, 32'h0004_0000);
    pin_in = '0; settle();
    rd(STAT, v); chk("R7 both fall", v, 32'h0004_0000);
    rd(EDGE, v); chk("R9 both falling", v, 32'h0001_0000);
    wr(STAT, 32'hFFFF_FFFF);
  endtask

  task automatic t_polarity_edges();
    logic [31:0] v;
    wr(REN, 32'd0); wr(FEN, 32'h0100_0000);
    wr(POL, 32'h0100_0000); settle();
    rd(STAT, v); chk("R8 polarity change no edge", v, 32'd0);
    pin_in = 32'h0100_0000; settle();
    rd(STAT, v); chk("R8 raw rise is logical fall", v, 32'h0100_0000);
    wr(STAT, 32'hFFFF_FFFF);
    wr(FEN, 32'd0); wr(POL, 32'd0);
    pin_in = '0; settle();
    rd(STAT, v); chk("R6 disabled edge ignored", v, 32'd0);
  endtask

  task automatic t_collision();
    logic [31:0] v;
    wr(REN, 32'h0000_0001);
    @(negedge clk); pin_in = 32'h0000_0001;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = STAT; req_wdata = 32'h0000_0001;
    @(negedge clk);
    req_valid = 0; req_write = 0;
    rd(STAT, v); chk("R11 event beats clear", v, 32'h0000_0001);
    wr(STAT, 32'h0000_0001);
    rd(STAT, v); chk("R11 later clear works", v, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_output();
    t_input();
    t_rise_fall();
    t_polarity_edges();
    t_collision();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule